// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block sits on an 8-bit host bus and drives three 8-bit peripheral ports, called A, B and C. A single control word, written through the host bus, picks a mode and a direction for each port group. Group A is port A plus the upper half of port C. Group B is port B plus the lower half of port C. Every peripheral pin is brought out as a separate input value, output value and output enable, so the pad ring can build the tri-state drivers.

In the plain mode, each port is a simple latched output or a direct input, and the two halves of port C are set independently of each other. In the strobed mode, port A or port B can capture data on a strobe or hand data over with an acknowledge. Fixed port C pins then carry the strobe, acknowledge, buffer-full and interrupt lines. The host bus is synchronous to `clk`. A write is taken at the rising edge where `cs` and `wr` are both high. Read data is presented combinationally while `cs` and `rd` are both high. A read of a strobed input port clears its flags at that edge. Peripheral strobe and acknowledge pins are assumed to be synchronous to `clk`.

Top module: `parport_ctrl`

## Requirements
- R1: After reset every port is an input: `pa_oe`, `pb_oe` and `pc_oe` are all zero, all output latches read 0, and no handshake flag is set.
- R2: A control word with bit 7 set loads the port directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 3 sets PC7..PC4, bit 1 sets port B and bit 0 sets PC3..PC0. An output port drives all of its enables high.
- R3: A write to the control address with bit 7 clear changes neither the directions nor the latches.
- R4: `sel` 00 addresses port A, 01 port B, 10 port C and 11 the control register. In the plain mode a write appears on the port's output pins, a read of an output port returns its latch, and a read of an input port returns its pins.
- R5: In the plain mode the port C halves take their directions independently. A read of port C returns the latch for output bits and the pins for input bits.
- R6: A valid control word clears all three output latches and all handshake flags.
- R7: `dout_en` is high only while `cs` and `rd` are both high, and a read of the control address returns 0.
- R8: Group A mode bits 6:5 = 01 with port A as input work as follows. A falling edge on PC4 captures `pa_in` and sets PC5 (buffer full, active high) and PC3 (interrupt, active high). A port A read returns the captured byte and clears both PC5 and PC3.
- R9: Group A mode bits 6:5 = 01 with port A as output work as follows. A write to port A drives PC7 low (buffer full, active low) and clears PC3. A falling edge on PC6 (acknowledge) returns PC7 high and sets PC3. PC6 is an input.
- R10: Bit 2 set puts port B in the strobed mode. PC2 is the strobe or acknowledge input, PC1 is buffer full (active high for input, active low for output), and PC0 is the interrupt.
- R11: Port C pins not taken by a strobed group keep the direction of their half and are driven from the port C latch.
- R12: A group A mode field with bit 6 set (the bidirectional mode) is handled as the plain mode.
- R13: Only a falling edge triggers a strobe or acknowledge. A pin held low does not set the flags again after a read has cleared them.
- R14: With `cs` low, neither a write strobe nor a read strobe has any effect on the latches or on the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| sel | input | 2 | Register select |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_en | output | 1 | Host read data enable (low means high impedance) |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest situation to reach from the ports is a strobe pin that stays low across a host read. A correct design clears the flags and leaves them clear, while a level-sensitive design sets them again at once. The stimulus pulls PC4 low and holds it there over several cycles. It reads port A while the pin is still low, then waits further cycles before checking PC5 and PC3. Changing `pa_in` after the strobe edge also shows that the read returns the captured byte and not the live pins.

// File: rtl/parport_pkg.sv
package parport_pkg;

  localparam int unsigned PORT_W     = 8;
  localparam int unsigned HALF_W     = PORT_W / 2;
  localparam int unsigned NUM_PORTS  = 3;
  localparam int unsigned NUM_GROUPS = 2;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned MODE_SET_BIT = 7;

  // register select encoding
  localparam logic [SEL_W-1:0] SEL_PA   = 2'b00;
  localparam logic [SEL_W-1:0] SEL_PB   = 2'b01;
  localparam logic [SEL_W-1:0] SEL_PC   = 2'b10;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'b11;

  // fixed port C handshake pin positions
  localparam int unsigned PC_INTR_B = 0;
  localparam int unsigned PC_BUF_B  = 1;
  localparam int unsigned PC_STB_B  = 2;
  localparam int unsigned PC_INTR_A = 3;
  localparam int unsigned PC_STB_A  = 4;
  localparam int unsigned PC_IBF_A  = 5;
  localparam int unsigned PC_ACK_A  = 6;
  localparam int unsigned PC_OBF_A  = 7;

  typedef struct packed {
    logic a_hs;   // group A strobed mode
    logic a_in;   // port A input
    logic cu_in;  // upper port C half input
    logic b_hs;   // group B strobed mode
    logic b_in;   // port B input
    logic cl_in;  // lower port C half input
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                 b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic cfg_t decode_cfg(input logic [PORT_W-1:0] w);
    cfg_t c;
    // mode field 01 selects strobed; 1x (bidirectional) falls back to plain
    c.a_hs  = (w[6:5] == 2'b01);
    c.a_in  = w[4];
    c.cu_in = w[3];
    c.b_hs  = w[2];
    c.b_in  = w[1];
    c.cl_in = w[0];
    return c;
  endfunction

endpackage

// File: rtl/parport_cfg_reg.sv
module parport_cfg_reg
  import parport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [PORT_W-1:0] wdata,
  output cfg_t              cfg,
  output logic              load
);

  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    load  = wr_ctrl & wdata[MODE_SET_BIT];
    cfg_d = cfg_q;
    if (load) begin
      cfg_d = decode_cfg(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/parport_latch.sv
module parport_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | we;
    q_d  = clr ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/parport_hs_chan.sv
module parport_hs_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dir_in,
  input  logic         clr,
  input  logic         stb_pin,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] port_in,
  output logic [W-1:0] cap,
  output logic         full,
  output logic         intr
);

  logic         stb_q;
  logic         stb_fall;
  logic [W-1:0] cap_q;
  logic         cap_we;
  logic         full_q, full_d;
  logic         intr_q, intr_d;

  always_comb begin
    stb_fall = stb_q & ~stb_pin;
    cap_we   = 1'b0;
    full_d   = full_q;
    intr_d   = intr_q;
    if (clr || !en) begin
      full_d = 1'b0;
      intr_d = 1'b0;
    end else if (dir_in) begin
      if (stb_fall) begin
        cap_we = 1'b1;
        full_d = 1'b1;
        intr_d = 1'b1;
      end else if (host_rd) begin
        full_d = 1'b0;
        intr_d = 1'b0;
      end
    end else begin
      if (host_wr) begin
        full_d = 1'b1;
        intr_d = 1'b0;
      end else if (stb_fall) begin
        full_d = 1'b0;
        intr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b1;
      full_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      stb_q  <= stb_pin;
      full_q <= full_d;
      intr_q <= intr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_we) begin
      cap_q <= port_in;
    end
  end

  assign cap  = cap_q;
  assign full = full_q;
  assign intr = intr_q;

endmodule

// File: rtl/parport_ctrl.sv
module parport_ctrl
  import parport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_en,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // host access decode
  logic                 acc_wr;
  logic                 acc_rd;
  logic [NUM_PORTS-1:0] wr_port;
  logic [NUM_PORTS-1:0] rd_port;
  logic                 wr_ctrl;

  always_comb begin
    acc_wr  = cs & wr;
    acc_rd  = cs & rd;
    wr_ctrl = acc_wr & (sel == SEL_CTRL);
    for (int i = 0; i < NUM_PORTS; i++) begin
      wr_port[i] = acc_wr & (sel == SEL_W'(i));
      rd_port[i] = acc_rd & (sel == SEL_W'(i));
    end
  end

  // control word
  cfg_t cfg_q;
  logic cfg_load;

  parport_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (din),
    .cfg     (cfg_q),
    .load    (cfg_load)
  );

  // output latches, one per port
  logic [NUM_PORTS-1:0][PORT_W-1:0] lat_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_latch
    parport_latch #(.W(PORT_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (cfg_load),
      .we    (wr_port[p]),
      .d     (din),
      .q     (lat_q[p])
    );
  end

  // handshake channels: group 0 is port A, group 1 is port B
  logic [NUM_GROUPS-1:0]             hs_en;
  logic [NUM_GROUPS-1:0]             hs_dir;
  logic [NUM_GROUPS-1:0]             hs_stb;
  logic [NUM_GROUPS-1:0][PORT_W-1:0] hs_pin;
  logic [NUM_GROUPS-1:0][PORT_W-1:0] hs_cap;
  logic [NUM_GROUPS-1:0]             hs_full;
  logic [NUM_GROUPS-1:0]             hs_intr;

  always_comb begin
    hs_en     = {cfg_q.b_hs, cfg_q.a_hs};
    hs_dir    = {cfg_q.b_in, cfg_q.a_in};
    hs_stb[0] = cfg_q.a_in ? pc_in[PC_STB_A] : pc_in[PC_ACK_A];
    hs_stb[1] = pc_in[PC_STB_B];
    hs_pin[0] = pa_in;
    hs_pin[1] = pb_in;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hs
    parport_hs_chan #(.W(PORT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en      (hs_en[g]),
      .dir_in  (hs_dir[g]),
      .clr     (cfg_load),
      .stb_pin (hs_stb[g]),
      .host_wr (wr_port[g]),
      .host_rd (rd_port[g]),
      .port_in (hs_pin[g]),
      .cap     (hs_cap[g]),
      .full    (hs_full[g]),
      .intr    (hs_intr[g])
    );
  end

  // ports A and B pin drive and read-back
  logic [NUM_GROUPS-1:0][PORT_W-1:0] grp_rd;

  always_comb begin
    pa_out = lat_q[0];
    pb_out = lat_q[1];
    pa_oe  = {PORT_W{~cfg_q.a_in}};
    pb_oe  = {PORT_W{~cfg_q.b_in}};
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (hs_dir[g]) begin
        grp_rd[g] = hs_en[g] ? hs_cap[g] : hs_pin[g];
      end else begin
        grp_rd[g] = lat_q[g];
      end
    end
  end

  // port C pin map
  always_comb begin
    pc_oe  = {{HALF_W{~cfg_q.cu_in}}, {HALF_W{~cfg_q.cl_in}}};
    pc_out = lat_q[2];
    if (cfg_q.a_hs) begin
      pc_oe[PC_INTR_A]  = 1'b1;
      pc_out[PC_INTR_A] = hs_intr[0];
      if (cfg_q.a_in) begin
        pc_oe[PC_STB_A]  = 1'b0;
        pc_oe[PC_IBF_A]  = 1'b1;
        pc_out[PC_IBF_A] = hs_full[0];
      end else begin
        pc_oe[PC_ACK_A]  = 1'b0;
        pc_oe[PC_OBF_A]  = 1'b1;
        pc_out[PC_OBF_A] = ~hs_full[0];
      end
    end
    if (cfg_q.b_hs) begin
      pc_oe[PC_STB_B]   = 1'b0;
      pc_oe[PC_BUF_B]   = 1'b1;
      pc_out[PC_BUF_B]  = cfg_q.b_in ? hs_full[1] : ~hs_full[1];
      pc_oe[PC_INTR_B]  = 1'b1;
      pc_out[PC_INTR_B] = hs_intr[1];
    end
  end

  // host read mux
  logic [PORT_W-1:0] pc_rd;

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      pc_rd[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
    end
    dout_en = acc_rd;
    unique case (sel)
      SEL_PA:  dout = grp_rd[0];
      SEL_PB:  dout = grp_rd[1];
      SEL_PC:  dout = pc_rd;
      default: dout = '0;
    endcase
    if (!acc_rd) begin
      dout = '0;
    end
  end

endmodule

// File: rtl/parport_sva.sv
module parport_sva
  import parport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [SEL_W-1:0]  sel,
  input logic [PORT_W-1:0] din,
  input logic              dout_en,
  input cfg_t              cfg,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pc_in,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe
);

  logic ctrl_ld;
  logic wr_a;
  logic wr_b;

  assign ctrl_ld = cs & wr & (sel == SEL_CTRL) & din[MODE_SET_BIT];
  assign wr_a    = cs & wr & (sel == SEL_PA);
  assign wr_b    = cs & wr & (sel == SEL_PB);

  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> !dout_en);

  assert_ctrl_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && sel == SEL_CTRL && !din[MODE_SET_BIT]) |=> $stable(cfg));

  assert_no_cs_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(pa_out) && $stable(pb_out)));

  assert_ibf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_hs && cfg.a_in && $fell(pc_in[PC_STB_A]) && !ctrl_ld)
      |=> (pc_out[PC_IBF_A] && pc_out[PC_INTR_A]));

  assert_obf_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_hs && !cfg.a_in && wr_a)
      |=> (!pc_out[PC_OBF_A] && pc_oe[PC_OBF_A] && !pc_out[PC_INTR_A]));

  assert_obf_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_hs && !cfg.a_in && $fell(pc_in[PC_ACK_A]) && !ctrl_ld && !wr_a)
      |=> (pc_out[PC_OBF_A] && pc_out[PC_INTR_A]));

  assert_b_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.b_hs && cfg.b_in && $fell(pc_in[PC_STB_B]) && !ctrl_ld)
      |=> (pc_out[PC_BUF_B] && pc_out[PC_INTR_B]));

  assert_b_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.b_hs && !cfg.b_in && wr_b) |=> !pc_out[PC_BUF_B]);

endmodule

bind parport_ctrl parport_sva u_parport_sva (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs      (cs),
  .rd      (rd),
  .wr      (wr),
  .sel     (sel),
  .din     (din),
  .dout_en (dout_en),
  .cfg     (cfg_q),
  .pa_out  (pa_out),
  .pb_out  (pb_out),
  .pc_in   (pc_in),
  .pc_out  (pc_out),
  .pc_oe   (pc_oe)
);

// File: tb/test_parport_ctrl.sv
`timescale 1ns/1ps
module test_parport_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, rd, wr;
  logic [1:0] sel;
  logic [7:0] din, dout;
  logic       dout_en;
  logic [7:0] pa_in, pa_out, pa_oe;
  logic [7:0] pb_in, pb_out, pb_oe;
  logic [7:0] pc_in, pc_out, pc_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  parport_ctrl i_parport_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .sel(sel),
    .din(din), .dout(dout), .dout_en(dout_en),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; sel = s; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] d, output logic en);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; sel = s;
    #1;
    d  = dout;
    en = dout_en;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic       e;
    rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; sel = 2'b00; din = 8'h00;
    pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    chk("R7 idle dout_en", {7'd0, dout_en}, 8'h01 & 8'h00);
    pa_in = 8'h3E;
    bus_rd(2'b00, d, e);
    chk("R4 read input pins A", d, 8'h3E);
  endtask

  task automatic t_mode0();
    logic [7:0] d;
    logic       e;
    bus_wr(2'b11, 8'h80);
    chk("R2 pa_oe all out", pa_oe, 8'hFF);
    chk("R2 pb_oe all out", pb_oe, 8'hFF);
    chk("R2 pc_oe all out", pc_oe, 8'hFF);
    bus_wr(2'b00, 8'h5A);
    bus_wr(2'b01, 8'hC3);
    bus_wr(2'b10, 8'h96);
    chk("R4 pa_out", pa_out, 8'h5A);
    chk("R4 pb_out", pb_out, 8'hC3);
    chk("R4 pc_out", pc_out, 8'h96);
    bus_rd(2'b00, d, e);
    chk("R4 read latch A", d, 8'h5A);
    bus_rd(2'b01, d, e);
    chk("R4 read latch B", d, 8'hC3);
    bus_rd(2'b11, d, e);
    chk("R7 ctrl read data", d, 8'h00);
    chk("R7 ctrl read enable", {7'd0, e}, 8'h01);
  endtask

  task automatic t_dirs();
    logic [7:0] d;
    logic       e;
    bus_wr(2'b11, 8'h93);
    chk("R2 A in", pa_oe, 8'h00);
    chk("R2 B in", pb_oe, 8'h00);
    chk("R2 C upper out lower in", pc_oe, 8'hF0);
    bus_wr(2'b11, 8'h88);
    chk("R5 C upper in lower out", pc_oe, 8'h0F);
    chk("R2 A out", pa_oe, 8'hFF);
    bus_wr(2'b10, 8'hA5);
    pc_in = 8'h3F;
    bus_rd(2'b10, d, e);
    chk("R5 mixed C read", d, 8'h35);
    chk("R5 lower C drive", {4'd0, pc_out[3:0]}, 8'h05);
    pc_in = 8'hFF;
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    logic       e;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h11);
    bus_wr(2'b11, 8'h1B);
    chk("R3 dir kept", pa_oe, 8'hFF);
    chk("R3 latch kept", pa_out, 8'h11);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; sel = 2'b00; din = 8'h77;
    @(negedge clk);
    wr = 1'b0;
    chk("R14 write without cs", pa_out, 8'h11);
    rd = 1'b1;
    #1;
    chk("R14 read without cs", {7'd0, dout_en}, 8'h00);
    @(negedge clk);
    rd = 1'b0;
    bus_wr(2'b11, 8'h80);
    chk("R6 latch cleared A", pa_out, 8'h00);
  endtask

  task automatic t_a_in();
    logic [7:0] d;
    logic       e;
    pa_in = 8'h6D;
    bus_wr(2'b11, 8'hB0);
    chk("R11 pc_oe A strobed in", pc_oe, 8'hEF);
    chk("R8 pa_oe", pa_oe, 8'h00);
    chk("R8 flags idle", {6'd0, pc_out[5], pc_out[3]}, 8'h00);
    bus_wr(2'b10, 8'hC0);
    chk("R11 PC7 PC6 from latch", {6'd0, pc_out[7:6]}, 8'h03);
    @(negedge clk);
    pc_in[4] = 1'b0;
    @(negedge clk);
    chk("R8 strobe sets flags", {6'd0, pc_out[5], pc_out[3]}, 8'h03);
    pa_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 flags held", {6'd0, pc_out[5], pc_out[3]}, 8'h03);
    bus_rd(2'b00, d, e);
    chk("R8 captured byte", d, 8'h6D);
    chk("R8 read clears", {6'd0, pc_out[5], pc_out[3]}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R13 held low no retrigger", {6'd0, pc_out[5], pc_out[3]}, 8'h00);
    pc_in[4] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_a_out();
    bus_wr(2'b11, 8'hA8);
    chk("R9 pc_oe A strobed out", pc_oe, 8'h8F);
    chk("R9 pa_oe", pa_oe, 8'hFF);
    chk("R9 idle obf high intr low", {6'd0, pc_out[7], pc_out[3]}, 8'h02);
    bus_wr(2'b00, 8'h3C);
    chk("R9 data out", pa_out, 8'h3C);
    chk("R9 write obf low", {6'd0, pc_out[7], pc_out[3]}, 8'h00);
    pc_in[6] = 1'b0;
    @(negedge clk);
    chk("R9 ack", {6'd0, pc_out[7], pc_out[3]}, 8'h03);
    pc_in[6] = 1'b1;
    bus_wr(2'b00, 8'h44);
    chk("R9 rewrite", {6'd0, pc_out[7], pc_out[3]}, 8'h00);
  endtask

  task automatic t_b();
    logic [7:0] d;
    logic       e;
    pb_in = 8'h42;
    bus_wr(2'b11, 8'h86);
    chk("R10 pc_oe B strobed in", pc_oe, 8'hFB);
    chk("R10 pb_oe in", pb_oe, 8'h00);
    @(negedge clk);
    pc_in[2] = 1'b0;
    @(negedge clk);
    pc_in[2] = 1'b1;
    chk("R10 B strobe flags", {6'd0, pc_out[1], pc_out[0]}, 8'h03);
    bus_rd(2'b01, d, e);
    chk("R10 B captured", d, 8'h42);
    chk("R10 B read clears", {6'd0, pc_out[1], pc_out[0]}, 8'h00);
    bus_wr(2'b11, 8'h84);
    chk("R10 pb_oe out", pb_oe, 8'hFF);
    chk("R10 B out idle", {6'd0, pc_out[1], pc_out[0]}, 8'h02);
    bus_wr(2'b01, 8'h99);
    chk("R10 B data", pb_out, 8'h99);
    chk("R10 B obf low", {6'd0, pc_out[1], pc_out[0]}, 8'h00);
    pc_in[2] = 1'b0;
    @(negedge clk);
    pc_in[2] = 1'b1;
    chk("R10 B ack", {6'd0, pc_out[1], pc_out[0]}, 8'h03);
  endtask

  task automatic t_mode2();
    bus_wr(2'b11, 8'hC0);
    chk("R12 pa_oe", pa_oe, 8'hFF);
    chk("R12 pc_oe plain", pc_oe, 8'hFF);
    chk("R12 pc_out latch", pc_out, 8'h00);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_dirs();
    t_ignore();
    t_a_in();
    t_a_out();
    t_b();
    t_mode2();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule